// File: doc/BRIEF.md
# Accumulator ALU with Flags and Decimal Adjust

This block is the arithmetic core of an 8-bit processor datapath. It keeps an accumulator, a shadow copy of the accumulator that serves as the first operand, and a second-operand holding register loaded from the internal bus. It also keeps a five-bit flag register. One operation code per cycle picks a sum, a difference, a bitwise function, a compare, one of four rotates or a decimal correction. The result goes either back into the accumulator or into a bus-side result latch, and the flags the operation affects are updated in the same clock.

The surrounding decoder sequences the block. It loads the second operand from the bus, copies the accumulator into the shadow operand, and then issues the operation with its destination select. Every state element is registered, so each load or operation becomes visible at the ports one clock after it is presented.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, both operand latches, the bus-side result latch and all five flags to zero.
- R2: `ld_tmp` captures `bus_in` into the second operand, `ld_act` copies the accumulator into the first operand, and `ld_acc_bus` loads `bus_in` into the accumulator, each at the next clock edge. When an operation writes the accumulator in the same cycle as `ld_acc_bus`, the operation's result wins.
- R3: Add (`op_sel`=0) gives first+second, and add-with-carry (1) also adds CY. CY takes the carry out of bit 7 and AC takes the carry out of bit 3.
- R4: Subtract (2) gives first-second, and subtract-with-borrow (3) also subtracts CY. CY is set on a borrow out of bit 7 and AC on a borrow out of bit 3.
- R5: AND (4), XOR (5) and OR (6) give the bitwise result of the two operands and clear both CY and AC.
- R6: Compare (7) sets all five flags exactly as subtract would. It leaves the accumulator and the bus-side result latch unchanged.
- R7: Rotate-left (8) and rotate-right (9) move the end bit around and into CY. Left-through-carry (10) and right-through-carry (11) rotate the nine bits made of CY and the operand. Rotates change CY only and leave S, Z, AC and P as they were.
- R8: Decimal adjust (12) works on the accumulator itself. It adds 0x06 when the low nibble exceeds 9 or AC is set, with AC taking that nibble's carry. It then adds 0x60 when the high nibble of the intermediate value exceeds 9, the intermediate sum overflowed, or CY is set. CY is set exactly when this second correction is applied.
- R9: `flags_out` is {S, Z, AC, P, CY} from bit 4 down to bit 0. Whenever S, Z and P are updated, S is result bit 7, Z is set for a zero result, and P is set for an even count of one bits.
- R10: With `dest_acc`=1 the result is written to the accumulator. With `dest_acc`=0 it is written to `res_out`, and the accumulator keeps its value.
- R11: Operations read the first operand from the shadow copy. A later load of the accumulator does not change the operand until `ld_act` is pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | 8 | Internal bus value for operand and accumulator loads |
| ld_tmp | input | 1 | Load the second operand from the bus |
| ld_act | input | 1 | Copy the accumulator into the first operand |
| ld_acc_bus | input | 1 | Load the accumulator from the bus |
| op_valid | input | 1 | Perform the operation in `op_sel` this cycle |
| op_sel | input | 4 | Operation code (0..12, see requirements) |
| dest_acc | input | 1 | 1: result to accumulator, 0: result to bus latch |
| acc_out | output | 8 | Accumulator value |
| res_out | output | 8 | Bus-side result latch |
| flags_out | output | 5 | {S, Z, AC, P, CY} |

## Verification
The bench goes after the carry-in paths: a design that ignores CY on add-with-carry or subtract-with-borrow, or that feeds CY into plain add and subtract, produces a result one off. It tests the subtract borrow at zero minus zero minus one and the nibble borrow that sets AC, where an inverted borrow sense flips both CY and AC. Decimal adjust is run in all four correction combinations, including the case where only CY forces the high correction and the case that wraps to zero; a wrong nibble test or a missed carry gives a non-decimal result or a lost CY. Rotate tests confirm the other flags survive and the through-carry forms use the old CY. Further tests cover compare, the bus destination and the shadow operand, where a design that writes the accumulator or reads the live accumulator is caught at `acc_out`.

// File: rtl/acc_alu_pkg.sv
// Shared definitions for the accumulator ALU: widths, flag bit
// positions and operation codes. Assumes an 8-bit datapath split
// into two 4-bit nibbles for the auxiliary carry.
package acc_alu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int FW = 5;

    localparam int F_CY = 0;
    localparam int F_P  = 1;
    localparam int F_AC = 2;
    localparam int F_Z  = 3;
    localparam int F_S  = 4;

    localparam logic [FW-1:0] MASK_ALL = '1;
    localparam logic [FW-1:0] MASK_CY  = FW'(1) << F_CY;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_RLC = 4'd8,
        OP_RRC = 4'd9,
        OP_RAL = 4'd10,
        OP_RAR = 4'd11,
        OP_DAA = 4'd12
    } alu_op_e;

    // True for the four rotate codes.
    function automatic logic is_rotate(alu_op_e op);
        return (op == OP_RLC) || (op == OP_RRC) || (op == OP_RAL) || (op == OP_RAR);
    endfunction

    // True for the three bitwise codes.
    function automatic logic is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
    endfunction
endpackage

// File: rtl/acc_alu_regs.sv
// Operand storage: accumulator, its shadow copy used as the first
// operand, and the second-operand register fed from the bus.
// Assumes an ALU write to the accumulator outranks a bus load.
module acc_alu_regs
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_in,
    input  logic          ld_tmp,
    input  logic          ld_act,
    input  logic          ld_acc_bus,
    input  logic          acc_wr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_q,
    output logic [DW-1:0] act_q,
    output logic [DW-1:0] tmp_q
);
    // Accumulator: ALU result first, bus load second.
    always_ff @(posedge clk) begin
        if (!rst_n)          acc_q <= '0;
        else if (acc_wr)     acc_q <= acc_wdata;
        else if (ld_acc_bus) acc_q <= bus_in;
    end

    // Shadow operand: snapshot of the accumulator on request.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (ld_act) act_q <= acc_q;
    end

    // Second operand: captured from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      tmp_q <= '0;
        else if (ld_tmp) tmp_q <= bus_in;
    end

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && !ld_acc_bus) |=> (acc_q == $past(acc_q)));

    // R2
    acc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (acc_q == $past(acc_wdata)));
endmodule

// File: rtl/acc_alu_arith.sv
// Combinational sum, difference, bitwise and rotate unit. Produces
// the result, new CY and AC, the set of flags the code updates and
// whether the result is stored. Assumes DW = 2*NW.
module acc_alu_arith
    import acc_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          cy_in,
    output logic [DW-1:0] res,
    output logic          cy_out,
    output logic          ac_out,
    output logic [FW-1:0] upd_mask,
    output logic          store_res
);
    logic          cin;
    logic [DW:0]   sum_w;
    logic [NW:0]   sum_lo;
    logic [DW:0]   dif_w;
    logic [NW:0]   dif_lo;

    // Carry or borrow selection and the two wide adders.
    always_comb begin
        cin    = ((op == OP_ADC) || (op == OP_SBB)) ? cy_in : 1'b0;
        sum_w  = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
        sum_lo = {1'b0, opa[NW-1:0]} + {1'b0, opb[NW-1:0]} + {{NW{1'b0}}, cin};
        dif_w  = {1'b0, opa} - {1'b0, opb} - {{DW{1'b0}}, cin};
        dif_lo = {1'b0, opa[NW-1:0]} - {1'b0, opb[NW-1:0]} - {{NW{1'b0}}, cin};
    end

    // Per-code result, carries and update mask.
    always_comb begin
        res       = '0;
        cy_out    = 1'b0;
        ac_out    = 1'b0;
        upd_mask  = MASK_ALL;
        store_res = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res    = sum_w[DW-1:0];
                cy_out = sum_w[DW];
                ac_out = sum_lo[NW];
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                res       = dif_w[DW-1:0];
                cy_out    = dif_w[DW];
                ac_out    = dif_lo[NW];
                store_res = (op != OP_CMP);
            end
            OP_AND: res = opa & opb;
            OP_XOR: res = opa ^ opb;
            OP_OR:  res = opa | opb;
            OP_RLC: begin
                res      = {opa[DW-2:0], opa[DW-1]};
                cy_out   = opa[DW-1];
                upd_mask = MASK_CY;
            end
            OP_RRC: begin
                res      = {opa[0], opa[DW-1:1]};
                cy_out   = opa[0];
                upd_mask = MASK_CY;
            end
            OP_RAL: begin
                res      = {opa[DW-2:0], cy_in};
                cy_out   = opa[DW-1];
                upd_mask = MASK_CY;
            end
            OP_RAR: begin
                res      = {cy_in, opa[DW-1:1]};
                cy_out   = opa[0];
                upd_mask = MASK_CY;
            end
            default: begin
                res       = '0;
                upd_mask  = '0;
                store_res = 1'b0;
            end
        endcase
    end

    // R5
    logic_carry_chk: assert final (!(is_logic(op) && (cy_out || ac_out)));
endmodule

// File: rtl/acc_alu_decadj.sv
// Combinational decimal correction of the accumulator after a
// packed-BCD add. Assumes the low correction is applied first and
// the high test looks at the intermediate value.
module acc_alu_decadj
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] acc,
    input  logic          ac_in,
    input  logic          cy_in,
    output logic [DW-1:0] res,
    output logic          ac_out,
    output logic          cy_out
);
    localparam logic [NW-1:0] NIB_MAX = NW'(9);
    localparam logic [NW:0]   LO_ADJ  = (NW+1)'(6);
    localparam logic [DW:0]   LO_ADJW = (DW+1)'(6);
    localparam logic [DW-1:0] HI_ADJ  = DW'(6) << NW;

    logic          lo_fix;
    logic          hi_fix;
    logic [NW:0]   lo_sum;
    logic [DW:0]   step1;

    // Two-stage nibble correction.
    always_comb begin
        lo_fix = (acc[NW-1:0] > NIB_MAX) || ac_in;
        lo_sum = {1'b0, acc[NW-1:0]} + (lo_fix ? LO_ADJ : '0);
        step1  = {1'b0, acc} + (lo_fix ? LO_ADJW : '0);
        hi_fix = (step1[DW-1:NW] > NIB_MAX) || step1[DW] || cy_in;
        res    = step1[DW-1:0] + (hi_fix ? HI_ADJ : '0);
        ac_out = lo_sum[NW];
        cy_out = hi_fix;
    end

    // R8
    daa_cy_keep_chk: assert final (!(cy_in && !cy_out));
endmodule

// File: rtl/acc_alu_flags.sv
// Five-bit flag register. On an update, each flag selected by the
// mask takes its new value; S, Z and P are derived from the result.
module acc_alu_flags
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [FW-1:0] mask,
    input  logic [DW-1:0] res,
    input  logic          cy_new,
    input  logic          ac_new,
    output logic [FW-1:0] flags_q
);
    logic [FW-1:0] cand;

    // Candidate flag vector from the result and carries.
    always_comb begin
        cand        = '0;
        cand[F_S]   = res[DW-1];
        cand[F_Z]   = (res == '0);
        cand[F_AC]  = ac_new;
        cand[F_P]   = ~^res;
        cand[F_CY]  = cy_new;
    end

    // Masked merge into the stored flags.
    always_ff @(posedge clk) begin
        if (!rst_n)   flags_q <= '0;
        else if (upd) flags_q <= (flags_q & ~mask) | (cand & mask);
    end

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> (flags_q == $past(flags_q)));
endmodule

// File: rtl/acc_alu.sv
// Top of the accumulator ALU. Ties the operand storage, the
// arithmetic unit, the decimal corrector and the flag register, and
// holds the bus-side result latch. Assumes at most one operation
// per cycle, issued by an external sequencer.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_in,
    input  logic          ld_tmp,
    input  logic          ld_act,
    input  logic          ld_acc_bus,
    input  logic          op_valid,
    input  logic [3:0]    op_sel,
    input  logic          dest_acc,
    output logic [7:0]    acc_out,
    output logic [7:0]    res_out,
    output logic [4:0]    flags_out
);
    alu_op_e       op;
    logic [DW-1:0] acc_q, act_q, tmp_q;
    logic [DW-1:0] ar_res, da_res, res_mux;
    logic          ar_cy, ar_ac, da_cy, da_ac, cy_mux, ac_mux;
    logic [FW-1:0] ar_mask, mask_mux;
    logic          ar_store, store_mux;
    logic          acc_wr;
    logic [DW-1:0] res_q;
    logic [FW-1:0] flags_q;
    logic          is_daa;

    assign op = alu_op_e'(op_sel);

    acc_alu_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_in),
        .ld_tmp     (ld_tmp),
        .ld_act     (ld_act),
        .ld_acc_bus (ld_acc_bus),
        .acc_wr     (acc_wr),
        .acc_wdata  (res_mux),
        .acc_q      (acc_q),
        .act_q      (act_q),
        .tmp_q      (tmp_q)
    );

    acc_alu_arith u_arith (
        .op        (op),
        .opa       (act_q),
        .opb       (tmp_q),
        .cy_in     (flags_q[F_CY]),
        .res       (ar_res),
        .cy_out    (ar_cy),
        .ac_out    (ar_ac),
        .upd_mask  (ar_mask),
        .store_res (ar_store)
    );

    acc_alu_decadj u_decadj (
        .acc    (acc_q),
        .ac_in  (flags_q[F_AC]),
        .cy_in  (flags_q[F_CY]),
        .res    (da_res),
        .ac_out (da_ac),
        .cy_out (da_cy)
    );

    // Pick the decimal corrector or the arithmetic unit.
    always_comb begin
        is_daa    = (op == OP_DAA);
        res_mux   = is_daa ? da_res  : ar_res;
        cy_mux    = is_daa ? da_cy   : ar_cy;
        ac_mux    = is_daa ? da_ac   : ar_ac;
        mask_mux  = is_daa ? MASK_ALL : ar_mask;
        store_mux = is_daa | ar_store;
        acc_wr    = op_valid && store_mux && dest_acc;
    end

    acc_alu_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (op_valid),
        .mask    (mask_mux),
        .res     (res_mux),
        .cy_new  (cy_mux),
        .ac_new  (ac_mux),
        .flags_q (flags_q)
    );

    // Bus-side result latch for results not sent to the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)                                res_q <= '0;
        else if (op_valid && store_mux && !dest_acc) res_q <= res_mux;
    end

    assign acc_out   = acc_q;
    assign res_out   = res_q;
    assign flags_out = flags_q;

    // R5
    logic_clears_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic(alu_op_e'(op_sel))) |=> !flags_out[F_CY]);

    // R7
    rotate_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_rotate(alu_op_e'(op_sel))) |=> (flags_out[F_S:F_P] == $past(flags_out[F_S:F_P])));

    // R6
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd7 && !ld_acc_bus) |=> (acc_out == $past(acc_out) && res_out == $past(res_out)));

    // R10
    bus_dest_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dest_acc && !ld_acc_bus) |=> (acc_out == $past(acc_out)));

    // R9
    parity_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dest_acc && op_sel != 4'd7 && !is_rotate(alu_op_e'(op_sel)) && op_sel <= 4'd12)
        |=> (flags_out[F_P] == ~^acc_out && flags_out[F_Z] == (acc_out == 8'h00) && flags_out[F_S] == acc_out[7]));
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = '0;
    logic       ld_tmp = 1'b0, ld_act = 1'b0, ld_acc_bus = 1'b0;
    logic       op_valid = 1'b0, dest_acc = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_out, res_out;
    logic [4:0] flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_tmp(ld_tmp),
        .ld_act(ld_act), .ld_acc_bus(ld_acc_bus), .op_valid(op_valid),
        .op_sel(op_sel), .dest_acc(dest_acc), .acc_out(acc_out),
        .res_out(res_out), .flags_out(flags_out)
    );

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       cin;
        logic [7:0] res;
        logic [4:0] fl;
        logic [4:0] msk;
    } vec_t;

    localparam int NV = 20;
    // flags order {S,Z,AC,P,CY}; R3 add, R4 sub, R5 logic, R6 compare, R7 rotates
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'h15, 8'h27, 1'b1, 8'h3C, 5'b00010, 5'b11111},
        '{4'd1,  8'h15, 8'h27, 1'b1, 8'h3D, 5'b00000, 5'b11111},
        '{4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 5'b01111, 5'b11111},
        '{4'd1,  8'h7F, 8'h00, 1'b1, 8'h80, 5'b10100, 5'b11111},
        '{4'd2,  8'h10, 8'h01, 1'b1, 8'h0F, 5'b00110, 5'b11111},
        '{4'd3,  8'h10, 8'h01, 1'b1, 8'h0E, 5'b00100, 5'b11111},
        '{4'd2,  8'h01, 8'h02, 1'b0, 8'hFF, 5'b10111, 5'b11111},
        '{4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 5'b10111, 5'b11111},
        '{4'd4,  8'hF0, 8'h3C, 1'b1, 8'h30, 5'b00010, 5'b11111},
        '{4'd6,  8'h0F, 8'h30, 1'b1, 8'h3F, 5'b00010, 5'b11111},
        '{4'd5,  8'hAA, 8'hAA, 1'b1, 8'h00, 5'b01010, 5'b11111},
        '{4'd5,  8'h81, 8'h00, 1'b0, 8'h81, 5'b10010, 5'b11111},
        '{4'd7,  8'h05, 8'h05, 1'b1, 8'h05, 5'b01010, 5'b11111},
        '{4'd7,  8'h03, 8'h05, 1'b0, 8'h03, 5'b10101, 5'b11111},
        '{4'd8,  8'h81, 8'h00, 1'b0, 8'h03, 5'b00001, 5'b00001},
        '{4'd9,  8'h81, 8'h00, 1'b0, 8'hC0, 5'b00001, 5'b00001},
        '{4'd10, 8'h81, 8'h00, 1'b0, 8'h02, 5'b00001, 5'b00001},
        '{4'd11, 8'h81, 8'h00, 1'b1, 8'hC0, 5'b00001, 5'b00001},
        '{4'd11, 8'h02, 8'h00, 1'b0, 8'h01, 5'b00000, 5'b00001},
        '{4'd10, 8'h40, 8'h00, 1'b1, 8'h81, 5'b00000, 5'b00001}
    };

    function automatic string req_of(logic [3:0] op);
        if (op <= 4'd1) return "R3";
        if (op <= 4'd3) return "R4";
        if (op <= 4'd6) return "R5";
        if (op == 4'd7) return "R6";
        if (op <= 4'd11) return "R7";
        return "R8";
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_acc(logic [7:0] v);
        bus_in = v; ld_acc_bus = 1'b1;
        @(negedge clk); ld_acc_bus = 1'b0;
    endtask

    task automatic copy_act();
        ld_act = 1'b1;
        @(negedge clk); ld_act = 1'b0;
    endtask

    task automatic load_tmp(logic [7:0] v);
        bus_in = v; ld_tmp = 1'b1;
        @(negedge clk); ld_tmp = 1'b0;
    endtask

    task automatic run_op(logic [3:0] op, logic dst);
        op_sel = op; dest_acc = dst; op_valid = 1'b1;
        @(negedge clk); op_valid = 1'b0;
    endtask

    // Put CY in a known state with a rotate sent to the bus latch.
    task automatic set_cy(logic v);
        load_acc(v ? 8'h80 : 8'h00);
        copy_act();
        run_op(4'd8, 1'b0);
    endtask

    task automatic setup_ops(logic [7:0] a, logic [7:0] b);
        load_acc(a);
        copy_act();
        load_tmp(b);
    endtask

    task automatic daa_case(logic [7:0] a, logic [7:0] b, logic [7:0] er, logic [4:0] ef);
        setup_ops(a, b);
        run_op(4'd0, 1'b1);
        run_op(4'd12, 1'b1);
        chk("R8", "daa result", acc_out, er);
        chk("R8", "daa flags", {3'b0, flags_out}, {3'b0, ef});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "acc after reset", acc_out, 8'h00);
        chk("R1", "res after reset", res_out, 8'h00);
        chk("R1", "flags after reset", {3'b0, flags_out}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            set_cy(VECS[i].cin);
            setup_ops(VECS[i].a, VECS[i].b);
            run_op(VECS[i].op, 1'b1);
            chk(req_of(VECS[i].op), $sformatf("vec%0d result", i), acc_out, VECS[i].res);
            chk(req_of(VECS[i].op), $sformatf("vec%0d flags", i),
                {3'b0, flags_out & VECS[i].msk}, {3'b0, VECS[i].fl});
        end

        // R7 rotate keeps S,Z,AC,P from the preceding XOR
        setup_ops(8'hAA, 8'hAA);
        run_op(4'd5, 1'b1);
        run_op(4'd8, 1'b1);
        chk("R7", "rotate acc", acc_out, 8'h55);
        chk("R7", "rotate keeps flags", {3'b0, flags_out}, {3'b0, 5'b01011});

        // R10 destination is the bus latch
        setup_ops(8'h20, 8'h03);
        run_op(4'd2, 1'b0);
        chk("R10", "bus result", res_out, 8'h1D);
        chk("R10", "acc kept", acc_out, 8'h20);
        chk("R9", "flags of bus result", {3'b0, flags_out}, {3'b0, 5'b00110});

        // R6 compare leaves the bus latch
        run_op(4'd7, 1'b0);
        chk("R6", "bus latch kept", res_out, 8'h1D);
        chk("R6", "acc kept", acc_out, 8'h20);

        // R11 operand is the shadow copy, not the live accumulator
        setup_ops(8'h10, 8'h01);
        load_acc(8'h99);
        run_op(4'd0, 1'b1);
        chk("R11", "shadow operand", acc_out, 8'h11);

        // R2 operation outranks a same-cycle bus load
        setup_ops(8'h30, 8'h02);
        bus_in = 8'hEE; ld_acc_bus = 1'b1;
        run_op(4'd0, 1'b1);
        ld_acc_bus = 1'b0;
        chk("R2", "priority", acc_out, 8'h32);
        load_acc(8'h5C);
        chk("R2", "bus load", acc_out, 8'h5C);

        // R8 decimal adjust, four correction patterns
        daa_case(8'h15, 8'h27, 8'h42, 5'b00110);
        daa_case(8'h19, 8'h28, 8'h47, 5'b00010);
        daa_case(8'h99, 8'h99, 8'h98, 5'b10001);
        daa_case(8'h50, 8'h50, 8'h00, 5'b01011);

        // R1 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "acc after late reset", acc_out, 8'h00);
        chk("R1", "res after late reset", res_out, 8'h00);
        chk("R1", "flags after late reset", {3'b0, flags_out}, 8'h00);
        run_op(4'd6, 1'b1);
        chk("R1", "operands cleared", acc_out, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule